// File: doc/BRIEF.md
# Write-Through Direct-Mapped Stalling Cache

This block sits between the memory port of a pipelined processor and a slower main memory. It keeps one 32-bit word per line in a direct-mapped array. A read that finds a valid line with a matching tag returns the word combinationally in the same cycle, with no stall. A read that misses raises the stall, fetches the word from main memory, installs it in the line and then releases the stall. The processor holds its request while stalled, so the access runs again and completes as a hit. This works the same way for instruction fetch and for data loads.

Writes never look at the tag. The indexed line takes the new tag and the new data and becomes valid. The same word is then written through to main memory at its full word address, and the processor waits until memory acknowledges it. Only one memory transaction is ever in flight. The memory side uses a request/acknowledge handshake and tolerates any latency. The number of lines is set by `IDX_W`: the default of 10 gives 4 KB, and `IDX_W = 14` gives 64 KB with the line index in address bits 15..2 and the tag in bits 31..16.

Top module: `wt_dm_cache`

## Requirements
- R1: After synchronous reset, `cpu_stall` and `mem_req` are low and every line is invalid, so the first read of any address misses.
- R2: A read whose line is valid and whose stored tag equals the address tag returns the stored word on `cpu_rdata` in the same cycle, with `cpu_stall` low (zero added cycles) and no memory request.
- R3: A read miss raises `cpu_stall` in the cycle the read is presented and issues `mem_req` with `mem_we` = 0. The stall stays high through the acknowledge cycle and drops one cycle later, so the added stall cycles equal the cycles `mem_req` was high plus one.
- R4: On the acknowledge of a read, the line stores `mem_rdata`, the tag of the missed address and a set valid bit, and the repeated read hits and returns the memory word.
- R5: Every write replaces the indexed line's tag and data and sets its valid bit, whether or not the line was valid or held another tag, so a following read of that address hits with zero stall.
- R6: Every write issues exactly one memory request with `mem_we` = 1 and the written word. `cpu_stall` is high from the write cycle until the acknowledge cycle and is low in that cycle, so the added stall cycles equal the cycles `mem_req` was high.
- R7: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay constant while a request is unacknowledged, and `mem_req` drops in the cycle after `mem_ack`.
- R8: Address bits 1..0 are ignored: they do not affect lookup or line selection, and `mem_addr` always carries them as zero.
- R9: The line index is `addr[IDX_W+1:2]` and the tag is `addr[31:IDX_W+2]`. Two addresses with the same index and different tags evict each other, while addresses with different indexes stay resident together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor byte address, held while stalled |
| cpu_wdata | input | DATA_W | Processor store data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe (takes priority over read) |
| cpu_rdata | output | DATA_W | Read data, valid when not stalled |
| cpu_stall | output | 1 | Processor must hold its access |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Write-through data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion pulse |

## Verification
The array update for a write and the launch of its write-through request happen at the same clock edge. The bench provokes this by writing to a line that already holds a different valid tag and to a line that has never been filled. It judges the outcome two ways: the memory model must receive exactly one write with the aligned address and the data, and an immediate read of the address must hit with zero stall cycles while the evicted address misses again. Fill and acknowledge also coincide: the line is written in the very edge that ends the read wait. The bench checks this with stall-cycle counts over several memory latencies.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_FILL   = 2'd1,
    ST_WRTHRU = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/wt_cache_store.sv
module wt_cache_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  // valid bits need a reset, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // tag and data arrays carry no reset, leaving them free to map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign lk_hit  = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_data = data_mem[lk_idx];

  AST_LINE_WRITE_HITS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag))) // R5
    else $error("line write did not install tag");
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hit,
  output logic              cpu_stall,
  output logic              cpu_line_wr,
  output logic              fill_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack
);
  ctl_state_e state_q, state_d;
  logic start_rd, start_wr;

  always_comb begin
    state_d     = state_q;
    cpu_stall   = 1'b0;
    start_rd    = 1'b0;
    start_wr    = 1'b0;
    cpu_line_wr = 1'b0;
    fill_wr     = 1'b0;
    unique case (state_q)
      ST_LOOKUP: begin
        if (cpu_wr) begin
          cpu_stall   = 1'b1;
          start_wr    = 1'b1;
          cpu_line_wr = 1'b1;
          state_d     = ST_WRTHRU;
        end else if (cpu_rd && !hit) begin
          cpu_stall = 1'b1;
          start_rd  = 1'b1;
          state_d   = ST_FILL;
        end
      end
      ST_FILL: begin
        cpu_stall = 1'b1;
        if (mem_ack) begin
          fill_wr = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_WRTHRU: begin
        cpu_stall = !mem_ack;
        if (mem_ack) state_d = ST_LOOKUP;
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_LOOKUP;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (start_rd || start_wr) begin
        mem_req   <= 1'b1;
        mem_we    <= start_wr;
        mem_addr  <= {cpu_addr[ADDR_W-1:2], 2'b00};
        mem_wdata <= cpu_wdata;
      end else if (mem_ack) begin
        mem_req <= 1'b0;
      end
    end
  end

  AST_WRITE_LAUNCHES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && cpu_wr) |=> (mem_req && mem_we)) // R6
    else $error("write did not launch write-through");
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))) // R7
    else $error("request changed before acknowledge");
  AST_REQ_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req) // R7
    else $error("request not dropped after acknowledge");
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  cpu_idx, mem_idx, wr_idx;
  logic [TAG_W-1:0]  cpu_tag, mem_tag, wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic              hit, cpu_line_wr, fill_wr;

  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign mem_idx = mem_addr[OFF_W +: IDX_W];
  assign mem_tag = mem_addr[ADDR_W-1 -: TAG_W];

  // a fill uses the latched miss address; a store uses the live address
  assign wr_idx  = fill_wr ? mem_idx   : cpu_idx;
  assign wr_tag  = fill_wr ? mem_tag   : cpu_tag;
  assign wr_data = fill_wr ? mem_rdata : cpu_wdata;

  wt_cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .lk_idx(cpu_idx), .lk_tag(cpu_tag), .lk_hit(hit), .lk_data(cpu_rdata),
    .wr_en(cpu_line_wr || fill_wr), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  wt_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .hit(hit), .cpu_stall(cpu_stall), .cpu_line_wr(cpu_line_wr), .fill_wr(fill_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack)
  );

  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && hit && !mem_req) |-> !cpu_stall) // R2
    else $error("hit stalled");
  AST_PENDING_STALLS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |-> cpu_stall) // R3
    else $error("stall low with request pending");
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> (hit || !$stable(cpu_addr))) // R4
    else $error("filled line missed");
  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)) // R8
    else $error("unaligned memory address");
endmodule

// File: tb/wt_dm_cache_tb.sv
module wt_dm_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  wt_dm_cache #(.ADDR_W(32), .DATA_W(32), .IDX_W(10)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0;

  // ---------------- main memory model ----------------
  logic [31:0] mm [logic [31:0]];
  int          lat_cfg = 2;
  int          cnt = 0;
  int          n_mrd = 0, n_mwr = 0, r7_viol = 0;
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] mm_get(logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (mm.exists(w)) return mm[w];
    return w ^ 32'h5A3C_0F96;
  endfunction

  always @(posedge clk) begin
    if (prev_pend && (!mem_req || mem_addr != prev_addr)) r7_viol++;
    prev_pend <= mem_req && !mem_ack;
    prev_addr <= mem_addr;
    if (rst) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_req) begin
      if (cnt >= lat_cfg) begin
        mem_ack   <= 1'b1;
        last_addr <= mem_addr;
        if (mem_we) begin
          mm[{mem_addr[31:2], 2'b00}] = mem_wdata;
          last_wdata <= mem_wdata;
          n_mwr++;
        end else begin
          mem_rdata <= mm_get(mem_addr);
          n_mrd++;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    forever begin
      #2;
      if (!cpu_stall) break;
      stalls++;
      @(negedge clk);
    end
    d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] v, output int stalls);
    stalls = 0;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1; cpu_rd = 1'b0;
    forever begin
      #2;
      if (!cpu_stall) break;
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  localparam logic [31:0] A_ADR = 32'h0000_1040;
  localparam logic [31:0] B_ADR = 32'h0004_1040; // same index as A, other tag
  localparam logic [31:0] D_ADR = 32'h0012_3A08;

  // ---------------- scenarios ----------------
  task automatic t_reset();
    #2;
    chk(cpu_stall == 1'b0, "R1 stall after reset", {31'b0, cpu_stall}, 32'd0);
    chk(mem_req == 1'b0, "R1 req after reset", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_cold_miss();
    logic [31:0] d; int s; int rd0;
    lat_cfg = 2; rd0 = n_mrd;
    do_read(A_ADR, d, s);
    chk(s == lat_cfg + 3, "R1 R3 cold miss stall cycles", s, lat_cfg + 3);
    chk(n_mrd == rd0 + 1, "R3 one memory read", n_mrd, rd0 + 1);
    chk(last_addr == A_ADR, "R3 miss address", last_addr, A_ADR);
    chk(d == mm_get(A_ADR), "R4 fill data", d, mm_get(A_ADR));
  endtask

  task automatic t_hit();
    logic [31:0] d; int s; int rd0;
    rd0 = n_mrd;
    do_read(A_ADR, d, s);
    chk(s == 0, "R2 hit zero stall", s, 0);
    chk(d == mm_get(A_ADR), "R2 hit data", d, mm_get(A_ADR));
    chk(n_mrd == rd0, "R2 no memory read on hit", n_mrd, rd0);
  endtask

  task automatic t_write_evict();
    logic [31:0] d; int s; int wr0;
    lat_cfg = 1; wr0 = n_mwr;
    do_write(B_ADR, 32'hCAFE_0001, s);
    chk(s == lat_cfg + 2, "R6 write stall cycles", s, lat_cfg + 2);
    chk(n_mwr == wr0 + 1, "R6 one memory write", n_mwr, wr0 + 1);
    chk(last_addr == B_ADR, "R6 write address", last_addr, B_ADR);
    chk(last_wdata == 32'hCAFE_0001, "R6 write data", last_wdata, 32'hCAFE_0001);
    do_read(B_ADR, d, s);
    chk(s == 0, "R5 read after write hits", s, 0);
    chk(d == 32'hCAFE_0001, "R5 written data", d, 32'hCAFE_0001);
    do_read(A_ADR, d, s);
    chk(s == lat_cfg + 3, "R9 evicted address misses", s, lat_cfg + 3);
    chk(d == mm_get(A_ADR), "R9 evicted address data", d, mm_get(A_ADR));
    do_read(B_ADR, d, s);
    chk(s == lat_cfg + 3, "R9 B evicted by A refill", s, lat_cfg + 3);
    chk(d == 32'hCAFE_0001, "R6 memory holds written word", d, 32'hCAFE_0001);
  endtask

  task automatic t_write_alloc();
    logic [31:0] d; int s;
    lat_cfg = 0;
    do_write(D_ADR, 32'h1357_9BDF, s);
    chk(s == lat_cfg + 2, "R6 write stall zero latency", s, lat_cfg + 2);
    do_read(D_ADR, d, s);
    chk(s == 0, "R5 write allocates invalid line", s, 0);
    chk(d == 32'h1357_9BDF, "R5 allocated data", d, 32'h1357_9BDF);
    do_read(B_ADR, d, s);
    chk(s == 0, "R9 other index still resident", s, 0);
  endtask

  task automatic t_offset();
    logic [31:0] d; int s;
    lat_cfg = 3;
    do_read(B_ADR | 32'h3, d, s);
    chk(s == 0, "R8 offset read hits", s, 0);
    chk(d == 32'hCAFE_0001, "R8 offset read data", d, 32'hCAFE_0001);
    do_write(B_ADR | 32'h2, 32'h0BAD_F00D, s);
    chk(last_addr == B_ADR, "R8 write address aligned", last_addr, B_ADR);
    do_read(B_ADR | 32'h1, d, s);
    chk(s == 0, "R8 offset after offset write", s, 0);
    chk(d == 32'h0BAD_F00D, "R8 same line data", d, 32'h0BAD_F00D);
  endtask

  task automatic t_latencies();
    logic [31:0] d; int s;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = 32'h0200_0000 + 32'(i * 64);
      lat_cfg = i * 3;
      do_read(a, d, s);
      chk(s == lat_cfg + 3, "R3 miss stall vs latency", s, lat_cfg + 3);
      chk(d == mm_get(a), "R4 fill data vs latency", d, mm_get(a));
    end
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = 32'h0200_0000 + 32'(i * 64);
      do_read(a, d, s);
      chk(s == 0, "R9 distinct indexes coexist", s, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cold_miss();
    t_hit();
    t_write_evict();
    t_write_alloc();
    t_offset();
    t_latencies();
    chk(r7_viol == 0, "R7 request stable until ack", r7_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule